// File: doc/BRIEF.md
# Converter Output Bus Interface

This block sits between the result register of a 12-bit converter and its parallel data pins. It decides when the pins may drive and what each pin carries. A host reads the converted value either as one 12-bit word or as two left-justified bytes over an 8-bit bus. In the byte case, an address bit selects which byte appears. The conversion engine is outside the block: it supplies the result word and a busy flag.

Each of the 12 output lines comes out as a data bit with its own enable, so tri-state behaviour can be modelled and checked without bidirectional pins. The pins are qualified by four control inputs together. Enables and data are registered on the rising clock edge, so every change of inputs shows at the outputs one edge later. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure. All inputs are plain levels that are sampled on every edge.

When the active byte changes, the block first spends one cycle with every line disabled. This keeps the two bytes from ever driving at the same moment, even though the address bit may toggle at any time.

Top module: `cvt_bus_if`

## Requirements
- R1: While reset is asserted, all 12 enables and all 12 data lines are 0.
- R2: Lines may be enabled only when read/convert is high, busy is low, chip enable is high and the active-low chip select is low, all at the same sampling edge. If any one of these fails at an edge, every enable is 0 after that edge.
- R3: With word mode high and access granted, all 12 enables are 1 one edge later and the data equals the result. The address bit has no effect on this.
- R4: With word mode low, access granted and the address bit low, only lines 11..4 are enabled. They carry result bits 11..4.
- R5: With word mode low, access granted and the address bit high, only lines 7..0 are enabled. Lines 7..4 carry 0 and lines 3..0 carry result bits 3..0.
- R6: When the granted enable pattern changes from one non-empty pattern to a different one (high byte, low byte or word), the block first holds one cycle with all enables 0. No two non-empty patterns are ever adjacent cycles.
- R7: A line whose enable is 0 drives data 0.
- R8: While a pattern stays enabled, the enabled data follows a change of the result one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result | input | 12 | Converted value from the conversion engine |
| busy | input | 1 | High while a conversion is in progress |
| rd_cnv | input | 1 | Read (high) / convert (low) line |
| chip_en | input | 1 | Active-high chip enable |
| cs_n | input | 1 | Active-low chip select |
| word_mode | input | 1 | High: full 12-bit word, low: two bytes |
| addr_sel | input | 1 | In byte mode, 0 selects the upper byte and 1 the lower byte |
| dout | output | 12 | Data value per line |
| doe | output | 12 | Output enable per line |

## Verification
Any input change that is present at a rising edge shows on `doe` and `dout` right after that edge, because there is exactly one register stage. A byte swap while access is granted is the exception. It gives an all-disabled pattern after the first edge and the new byte after the second. Inputs are driven on the falling edge, and each check samples shortly after the rising edge at which the result is due. The byte-swap checks sample twice, once for the gap and once for the new byte.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  // Which group of output lines is currently granted.
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_WORD = 2'd1,
    GRP_HI   = 2'd2,
    GRP_LO   = 2'd3
  } grp_t;
endpackage

// File: rtl/cbi_gate.sv
module cbi_gate
  import cbi_pkg::*;
(
  input  logic rd_cnv,
  input  logic busy,
  input  logic chip_en,
  input  logic cs_n,
  input  logic word_mode,
  input  logic addr_sel,
  output grp_t want
);
  logic access;

  // All four qualifiers must hold together.
  assign access = rd_cnv & ~busy & chip_en & ~cs_n;

  always_comb begin
    if (!access)        want = GRP_NONE;
    else if (word_mode) want = GRP_WORD;
    else if (addr_sel)  want = GRP_LO;
    else                want = GRP_HI;
  end
endmodule

// File: rtl/cbi_seq.sv
module cbi_seq
  import cbi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  grp_t want,
  output grp_t nxt
);
  grp_t cur;

  // A granted group may only be replaced after a cycle with none granted.
  always_comb begin
    if (cur != GRP_NONE && want != cur) nxt = GRP_NONE;
    else                                nxt = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= GRP_NONE;
    else        cur <= nxt;
  end
endmodule

// File: rtl/cbi_drive.sv
module cbi_drive
  import cbi_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  grp_t             grp,
  input  logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dout,
  output logic [RES_W-1:0] doe
);
  localparam int LO_W = RES_W - BYTE_W;

  for (genvar i = 0; i < RES_W; i++) begin : g_line
    logic en_d;
    logic dat_d;

    always_comb begin
      case (grp)
        GRP_WORD: begin en_d = 1'b1;              dat_d = result[i]; end
        GRP_HI:   begin en_d = (i >= LO_W);       dat_d = (i >= LO_W) ? result[i] : 1'b0; end
        GRP_LO:   begin en_d = (i < BYTE_W);      dat_d = (i < LO_W) ? result[i] : 1'b0; end
        default:  begin en_d = 1'b0;              dat_d = 1'b0; end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        doe[i]  <= 1'b0;
        dout[i] <= 1'b0;
      end else begin
        doe[i]  <= en_d;
        dout[i] <= dat_d;
      end
    end
  end
endmodule

// File: rtl/cvt_bus_if.sv
module cvt_bus_if
  import cbi_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] result,
  input  logic             busy,
  input  logic             rd_cnv,
  input  logic             chip_en,
  input  logic             cs_n,
  input  logic             word_mode,
  input  logic             addr_sel,
  output logic [RES_W-1:0] dout,
  output logic [RES_W-1:0] doe
);
  grp_t want;
  grp_t nxt;

  cbi_gate u_gate (
    .rd_cnv(rd_cnv), .busy(busy), .chip_en(chip_en), .cs_n(cs_n),
    .word_mode(word_mode), .addr_sel(addr_sel), .want(want)
  );

  cbi_seq u_seq (
    .clk(clk), .rst_n(rst_n), .want(want), .nxt(nxt)
  );

  cbi_drive #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .grp(nxt), .result(result),
    .dout(dout), .doe(doe)
  );
endmodule

// File: rtl/cbi_chk.sv
module cbi_chk #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] result,
  input logic             busy,
  input logic             rd_cnv,
  input logic             chip_en,
  input logic             cs_n,
  input logic             word_mode,
  input logic             addr_sel,
  input logic [RES_W-1:0] dout,
  input logic [RES_W-1:0] doe
);
  localparam int LO_W = RES_W - BYTE_W;
  localparam logic [RES_W-1:0] HI_MASK   = {{BYTE_W{1'b1}}, {LO_W{1'b0}}};
  localparam logic [RES_W-1:0] LO_MASK   = {{LO_W{1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [RES_W-1:0] WORD_MASK = {RES_W{1'b1}};

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (doe == '0 && dout == '0));

  // R2
  access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cnv && !busy && chip_en && !cs_n) |=> (doe == '0));

  // R3
  word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe == WORD_MASK) |-> $past(word_mode));

  // R4
  hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe == HI_MASK) |-> $past(!word_mode && !addr_sel));

  // R5
  lo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe == LO_MASK) |-> ($past(!word_mode && addr_sel) && dout[BYTE_W-1:LO_W] == '0));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(doe) != '0 && doe != '0) |-> (doe == $past(doe)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout & ~doe) == '0);

  // R8
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe == WORD_MASK) |-> (dout == $past(result)));
endmodule

bind cvt_bus_if cbi_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .result(result), .busy(busy), .rd_cnv(rd_cnv),
  .chip_en(chip_en), .cs_n(cs_n), .word_mode(word_mode), .addr_sel(addr_sel),
  .dout(dout), .doe(doe)
);

// File: tb/sim_cvt_bus_if.sv
module sim_cvt_bus_if;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] result = '0;
  logic        busy = 1'b1;
  logic        rd_cnv = 1'b0;
  logic        chip_en = 1'b0;
  logic        cs_n = 1'b1;
  logic        word_mode = 1'b1;
  logic        addr_sel = 1'b0;
  logic [11:0] dout;
  logic [11:0] doe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cvt_bus_if u0 (
    .clk(clk), .rst_n(rst_n), .result(result), .busy(busy), .rd_cnv(rd_cnv),
    .chip_en(chip_en), .cs_n(cs_n), .word_mode(word_mode), .addr_sel(addr_sel),
    .dout(dout), .doe(doe)
  );

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
    end
  endtask

  // Advance one rising edge and settle just after it.
  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic rd, input logic bz, input logic ce,
                       input logic cs, input logic wm, input logic a,
                       input logic [11:0] r);
    @(negedge clk);
    rd_cnv = rd; busy = bz; chip_en = ce; cs_n = cs;
    word_mode = wm; addr_sel = a; result = r;
  endtask

  task automatic go_idle();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, result);
    edge1(); edge1();
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "doe in reset", doe, 12'h000);
    chk("R1", "dout in reset", dout, 12'h000);
    edge1();
    chk("R1", "doe after reset edge", doe, 12'h000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_word();
    drive(1, 0, 1, 0, 1, 0, 12'hABC); edge1();
    chk("R3", "word doe", doe, 12'hFFF);
    chk("R3", "word dout", dout, 12'hABC);
    drive(1, 0, 1, 0, 1, 1, 12'hABC); edge1();
    chk("R3", "word doe, address high ignored", doe, 12'hFFF);
    chk("R3", "word dout, address high ignored", dout, 12'hABC);
    drive(1, 0, 1, 0, 1, 1, 12'h123); edge1();
    chk("R8", "word dout tracks result", dout, 12'h123);
    go_idle();
  endtask

  task automatic t_access();
    // R2: each qualifier removed in turn from a granted word read
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 1, 0, 1, 0, 12'h5A5); edge1();
      chk("R2", "granted before drop", doe, 12'hFFF);
      drive(k != 0, k == 1, k != 2, k == 3, 1, 0, 12'h5A5); edge1();
      chk("R2", "doe with one qualifier failed", doe, 12'h000);
      chk("R7", "dout with one qualifier failed", dout, 12'h000);
    end
    go_idle();
  endtask

  task automatic t_bytes();
    drive(1, 0, 1, 0, 0, 0, 12'hABC); edge1();
    chk("R4", "high byte doe", doe, 12'hFF0);
    chk("R4", "high byte dout", dout, 12'hAB0);
    drive(1, 0, 1, 0, 0, 1, 12'hFFF); edge1();
    chk("R6", "gap doe on byte swap", doe, 12'h000);
    edge1();
    chk("R5", "low byte doe", doe, 12'h0FF);
    chk("R5", "low byte dout padded", dout, 12'h00F);
    drive(1, 0, 1, 0, 0, 1, 12'h7A3); edge1();
    chk("R8", "low byte tracks result", dout, 12'h003);
    drive(1, 0, 1, 0, 0, 0, 12'h7A3); edge1();
    chk("R6", "gap doe on swap back", doe, 12'h000);
    edge1();
    chk("R4", "high byte after swap back", dout, 12'h7A0);
    drive(1, 0, 1, 0, 1, 0, 12'h7A3); edge1();
    chk("R6", "gap doe on byte to word", doe, 12'h000);
    edge1();
    chk("R3", "word after gap", doe, 12'hFFF);
    drive(1, 1, 1, 0, 0, 1, 12'h7A3); edge1();
    chk("R2", "busy raised mid read", doe, 12'h000);
    go_idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_word();
        t_access();
        t_bytes();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule